// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This unit carries out single-bit operations on one byte of memory for a processor's execute stage. The issuing logic presents a base register value, a displacement that arrives split into a 15-bit upper part and a separate low bit, a 3-bit bit number and a 2-bit operation subcode, together with a one-cycle start pulse. The unit joins the two displacement parts and sign-extends the result. It adds this to the base to form the byte address. It then reads that byte over a byte-wide request/acknowledge memory port.

From the bit as it was read, the unit derives a new zero flag. It hands a full status word to the processor status logic, with only the zero flag replaced. In invert mode the unit writes the byte back with the selected bit flipped, and the read and the write form one uninterrupted sequence. In test mode only the read takes place. Any other subcode is refused with a one-cycle unsupported pulse. A refused request touches neither memory nor flags.

Top module: `bitop_unit`

## Requirements
- R1: The memory address is the base plus the 16-bit displacement {disp_hi, disp_lo} sign-extended to 32 bits, modulo 2^32. It stays stable for as long as a request is held.
- R2: bit_sel = n selects the bit of weight 2^n in the addressed byte (0 is the least significant bit).
- R3: Invert (subcode 2'b01): the new Z is the inverse of the selected bit as read. Exactly one write follows the read, carrying the read byte with only the selected bit flipped.
- R4: Test (subcode 2'b11): the new Z is the inverse of the selected bit as read. Exactly one read cycle is issued and no write cycle.
- R5: A subcode of 2'b00 or 2'b10 raises unsupported_o for one cycle, one cycle after start. It issues no memory request and no psw_we_o pulse.
- R6: Each supported operation gives exactly one psw_we_o pulse. During that pulse psw_out bit 0 (Z) holds the new Z, and bits 4:1 (SAT, CY, OV, S) equal psw_in bits 4:1.
- R7: busy_o rises the cycle after an accepted start. It stays high until the final acknowledge: the write acknowledge for invert, or the read acknowledge for test. done_o then pulses for one cycle. A start raised while busy_o is high is ignored.
- R8: After reset, busy_o, mem_req_o, psw_we_o, done_o and unsupported_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| subcode_i | input | 2 | Operation select: 01 invert, 11 test |
| bit_sel_i | input | 3 | Bit number within the byte |
| base_i | input | 32 | Base register value |
| disp_hi_i | input | 15 | Upper 15 bits of the displacement |
| disp_lo_i | input | 1 | Lowest displacement bit |
| psw_i | input | 5 | Current status flags {SAT, CY, OV, S, Z} |
| psw_o | output | 5 | Updated status word, valid while psw_we_o is high |
| psw_we_o | output | 1 | Status write strobe |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write (1) or read (0) request |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished pulse |
| unsupported_o | output | 1 | Rejected subcode pulse |

## Verification
On every cycle, the assertions check the following. A write request only occurs in invert mode, and it differs from the read byte in exactly one bit. The new Z always opposes the bit as read. The address holds steady while a request is outstanding. busy_o cannot drop while a write awaits its acknowledge, and a rejected subcode coincides with neither activity nor a flag strobe. What only the scenarios can show is that the right byte at the right sign-extended address ends up with the expected content, that read and write counts per operation are exact, and that a start raised while busy_o is high leaves no trace.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } bitop_state_e;

  localparam logic [1:0] SUB_INVERT = 2'b01;
  localparam logic [1:0] SUB_TEST   = 2'b11;

  localparam int FLAG_W = 5;
  localparam int FLAG_Z = 0;

  function automatic logic sub_supported(input logic [1:0] sub);
    return (sub == SUB_INVERT) || (sub == SUB_TEST);
  endfunction

endpackage

// File: rtl/bitop_addr.sv
module bitop_addr #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-2:0] disp_hi_i,
  input  logic              disp_lo_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [DISP_W-1:0] disp;
  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp     = {disp_hi_i, disp_lo_i};
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    addr_o   = base_i + disp_ext;
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] flipped_o
);
  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx_i == IDX_W'(g));
  end

  always_comb begin
    bit_o     = |(data_i & mask);
    flipped_o = data_i ^ mask;
  end
endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        subcode_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_bit_i,
  input  logic [DATA_W-1:0] rd_flip_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [IDX_W-1:0]  bit_q_o,
  output logic              z_o,
  output logic              psw_we_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              unsupported_o
);
  bitop_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  bit_q, bit_d;
  logic              inv_q, inv_d;
  logic [DATA_W-1:0] rd_q, wd_q;
  logic              z_q;
  logic              psw_we_q, psw_we_d;
  logic              unsup_q, unsup_d;
  logic              cap_en;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    bit_d    = bit_q;
    inv_d    = inv_q;
    psw_we_d = 1'b0;
    unsup_d  = 1'b0;
    cap_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (sub_supported(subcode_i)) begin
            state_d = ST_RD;
            addr_d  = addr_i;
            bit_d   = bit_sel_i;
            inv_d   = (subcode_i == SUB_INVERT);
          end else begin
            unsup_d = 1'b1;
          end
        end
      end
      ST_RD: begin
        if (mem_ack_i) begin
          cap_en   = 1'b1;
          psw_we_d = 1'b1;
          state_d  = inv_q ? ST_WR : ST_DONE;
        end
      end
      ST_WR: begin
        if (mem_ack_i) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      bit_q    <= '0;
      inv_q    <= 1'b0;
      psw_we_q <= 1'b0;
      unsup_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      bit_q    <= bit_d;
      inv_q    <= inv_d;
      psw_we_q <= psw_we_d;
      unsup_q  <= unsup_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wd_q <= '0;
      z_q  <= 1'b0;
    end else if (cap_en) begin
      rd_q <= mem_rdata_i;
      wd_q <= rd_flip_i;
      z_q  <= ~rd_bit_i;
    end
  end

  assign bit_q_o       = bit_q;
  assign z_o           = z_q;
  assign psw_we_o      = psw_we_q;
  assign mem_req_o     = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o      = (state_q == ST_WR);
  assign mem_addr_o    = addr_q;
  assign mem_wdata_o   = wd_q;
  assign busy_o        = mem_req_o;
  assign done_o        = (state_q == ST_DONE);
  assign unsupported_o = unsup_q;

  AST_WRITE_ONLY_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> inv_q);                                  // R4
  AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> ($countones(mem_wdata_o ^ rd_q) == 1));  // R3
  AST_Z_OPPOSES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we_o |-> (z_o != rd_q[bit_q]));                                  // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && $past(mem_req_o)) |-> $stable(mem_addr_o));            // R1
  AST_BUSY_TILL_WACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o && !mem_ack_i) |=> busy_o);                   // R7
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported_o |-> (!busy_o && !psw_we_o));                           // R5
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        subcode_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-2:0] disp_hi_i,
  input  logic              disp_lo_i,
  input  logic [FLAG_W-1:0] psw_i,
  output logic [FLAG_W-1:0] psw_o,
  output logic              psw_we_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              unsupported_o
);
  logic [ADDR_W-1:0] ea;
  logic [IDX_W-1:0]  bit_q;
  logic              rd_bit;
  logic [DATA_W-1:0] rd_flip;
  logic              z_new;

  bitop_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_addr (
    .base_i    (base_i),
    .disp_hi_i (disp_hi_i),
    .disp_lo_i (disp_lo_i),
    .addr_o    (ea)
  );

  bitop_alu #(.DATA_W(DATA_W)) u_alu (
    .data_i    (mem_rdata_i),
    .idx_i     (bit_q),
    .bit_o     (rd_bit),
    .flipped_o (rd_flip)
  );

  bitop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .subcode_i     (subcode_i),
    .bit_sel_i     (bit_sel_i),
    .addr_i        (ea),
    .rd_bit_i      (rd_bit),
    .rd_flip_i     (rd_flip),
    .mem_rdata_i   (mem_rdata_i),
    .mem_ack_i     (mem_ack_i),
    .bit_q_o       (bit_q),
    .z_o           (z_new),
    .psw_we_o      (psw_we_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .unsupported_o (unsupported_o)
  );

  always_comb begin
    psw_o         = psw_i;
    psw_o[FLAG_Z] = z_new;
  end

  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we_o |-> (psw_o[FLAG_W-1:1] == psw_i[FLAG_W-1:1]));             // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);                                                // R7
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  sub = 2'b00;
  logic [2:0]  bsel = 3'd0;
  logic [31:0] base = '0;
  logic [14:0] dhi = '0;
  logic        dlo = 1'b0;
  logic [4:0]  psw_in = 5'b11110;
  logic [4:0]  psw_out;
  logic        psw_we, req, we, busy, done, unsup;
  logic [31:0] addr;
  logic [7:0]  wdata, rdata;
  logic        ack = 1'b0;

  logic [7:0]  mem [256];
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = '0, pre_data = '0;
  int          rd_cnt = 0, wr_cnt = 0, psw_cnt = 0, done_cnt = 0, unsup_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [4:0]  psw_seen = '0;
  int          checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  bitop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .subcode_i(sub), .bit_sel_i(bsel),
    .base_i(base), .disp_hi_i(dhi), .disp_lo_i(dlo), .psw_i(psw_in), .psw_o(psw_out),
    .psw_we_o(psw_we), .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ack_i(ack), .busy_o(busy),
    .done_o(done), .unsupported_o(unsup)
  );

  assign rdata = mem[addr[7:0]];

  always @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
    if (req && !ack) begin
      ack <= 1'b1;
      last_addr <= addr;
      if (we) begin
        mem[addr[7:0]] <= wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end else begin
      ack <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (psw_we) begin psw_cnt <= psw_cnt + 1; psw_seen <= psw_out; end
    if (done)   done_cnt  <= done_cnt + 1;
    if (unsup)  unsup_cnt <= unsup_cnt + 1;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      summary();
    end
  end

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_addr = a; pre_data = d; pre_we = 1'b1;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic issue(input logic [31:0] b, input logic [15:0] d, input logic [2:0] n,
                       input logic [1:0] s);
    @(negedge clk);
    base = b; dhi = d[15:1]; dlo = d[0]; bsel = n; sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 40; k++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // {base[32], disp[16], bit[3], sub[2], init[8], expected Z[1], expected byte[8]}
  localparam int NV = 6;
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_0100, 16'h0010, 3'd0, 2'b01, 8'h01, 1'b0, 8'h00},
    {32'h0000_0200, 16'h0021, 3'd7, 2'b01, 8'h00, 1'b1, 8'h80},
    {32'h0000_1040, 16'hFFF0, 3'd3, 2'b11, 8'h08, 1'b0, 8'h08},
    {32'h0000_0050, 16'h0005, 3'd5, 2'b11, 8'h00, 1'b1, 8'h00},
    {32'h8000_0000, 16'h8000, 3'd4, 2'b01, 8'hEF, 1'b1, 8'hFF},
    {32'hFFFF_FFF0, 16'h0013, 3'd2, 2'b01, 8'hA5, 1'b0, 8'hA1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 busy", busy, 0);
    check("R8 req", req, 0);
    check("R8 flags", {psw_we, done, unsup}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] vb, ea;
      logic [15:0] vd;
      logic [1:0]  vs;
      logic [7:0]  vi;
      int r0, w0, p0, d0;
      vb = VEC[i][69:38]; vd = VEC[i][37:22]; vs = VEC[i][18:17]; vi = VEC[i][16:9];
      ea = vb + {{16{vd[15]}}, vd};
      poke(ea[7:0], vi);
      r0 = rd_cnt; w0 = wr_cnt; p0 = psw_cnt; d0 = done_cnt;
      issue(vb, vd, VEC[i][21:19], vs);
      check("R7 busy after start", busy, 1);
      wait_done();
      check("R1 address", last_addr, ea);
      check("R3/R4 Z from selected bit (R2)", psw_seen[0], VEC[i][8]);
      check("R6 other flags kept", psw_seen[4:1], psw_in[4:1]);
      check("R6 one status strobe", psw_cnt - p0, 1);
      check("R2 memory byte", mem[ea[7:0]], VEC[i][7:0]);
      check("R4 read count", rd_cnt - r0, 1);
      check("R3 write count", wr_cnt - w0, (vs == 2'b01) ? 1 : 0);
      check("R7 one done, idle after", {done_cnt - d0, 31'(busy)}, {32'd1, 31'd0});
    end

    // R5: unsupported subcodes 00 and 10 leave memory and flags alone
    for (int s = 0; s < 4; s += 2) begin
      int r0, w0, p0, u0;
      poke(8'h77, 8'h5A);
      r0 = rd_cnt; w0 = wr_cnt; p0 = psw_cnt; u0 = unsup_cnt;
      issue(32'h0000_0070, 16'h0007, 3'd1, 2'(s));
      check("R5 unsupported pulse now", unsup, 1);
      repeat (4) @(negedge clk);
      check("R5 single pulse", unsup_cnt - u0, 1);
      check("R5 no memory cycles", (rd_cnt - r0) + (wr_cnt - w0), 0);
      check("R5 no flag strobe", psw_cnt - p0, 0);
      check("R5 byte unchanged", mem[8'h77], 8'h5A);
      check("R5 not busy", busy, 0);
    end

    // R7: start raised while busy is ignored; R3 invert with slow flag inputs
    begin
      int r0, w0, d0;
      poke(8'h40, 8'h00);
      r0 = rd_cnt; w0 = wr_cnt; d0 = done_cnt;
      issue(32'h0000_0040, 16'h0000, 3'd6, 2'b01);
      @(negedge clk);
      base = 32'h0000_0041; sub = 2'b11; start = 1'b1;
      check("R7 still busy", busy, 1);
      @(negedge clk);
      start = 1'b0;
      wait_done();
      repeat (3) @(negedge clk);
      check("R7 one read only", rd_cnt - r0, 1);
      check("R7 one write only", wr_cnt - w0, 1);
      check("R7 one done only", done_cnt - d0, 1);
      check("R3 bit 6 set", mem[8'h40], 8'h40);
      check("R3 Z was clear bit", psw_seen[0], 1);
    end

    // R8: reset mid-operation returns to idle
    issue(32'h0000_0010, 16'h0000, 3'd0, 2'b01);
    rst_n = 1'b0;
    #1;
    check("R8 async reset clears busy", busy, 0);
    check("R8 async reset clears req", req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule